// File: doc/BRIEF.md
# ADC Sequencer with Window Watchdog

This block schedules conversions on one shared analog-to-digital converter for two logical channels. The first is a regular channel, started by a trigger pulse or re-armed continuously. The second is a high-priority injected channel. The block issues a start strobe and a channel select to the converter, then waits for a done strobe that carries the converted value. If an injected trigger arrives while a regular conversion is in flight, the block halts that conversion with an abort strobe and converts the injected channel. It then restarts the regular channel so that its result is still delivered.

Every captured result passes through a window monitor with an upper and a lower bound. A value strictly above the upper bound or strictly below the lower bound sets a sticky watchdog flag. Separate enables decide whether regular results and injected results are monitored, and an interrupt enable gates the flag onto the interrupt line. The bounds are plain inputs and may change at any time. Each result is judged against the bounds present at the clock edge on which it is captured, so software can move the window to build hysteresis or several event levels.

Top module: `adcSeqWatch`

## Requirements
- R1: After reset, convStart, convSel, convAbort, both result registers, both end-of-conversion flags, wdFlag and irq are all 0.
- R2: A regTrig pulse seen while the block is idle produces one convStart with convSel=0 on the next edge. The convData present at the edge where convDone is sampled during that conversion is stored in regData, and regEoc is set on that edge.
- R3: An injected conversion (convSel=1) stores its convData in injData and sets injEoc on the convDone edge. Injected results never change regData or regEoc, and regular results never change injData or injEoc.
- R4: An injTrig seen during a regular conversion, on an edge without convDone, raises convAbort together with convStart and convSel=1. On the edge after the injected convDone, convStart with convSel=0 restarts the regular conversion, so the injected result arrives first and the regular result follows.
- R5: An injTrig seen while an injected conversion is in progress is ignored: no extra convStart is issued and only one injected result is produced.
- R6: While contMode is 1, a new regular conversion starts (convStart with convSel=0) two edges after the edge on which the previous regular result was captured.
- R7: A captured value sets wdFlag when it is greater than highThr or less than lowThr. A value equal to either bound is in range. Regular results are checked only when wdEnReg=1, and injected results only when wdEnInj=1.
- R8: wdFlag stays set until a clrWd pulse clears it. A new window hit on the same edge wins over the clear.
- R9: irq is 1 exactly when wdFlag is 1 and wdIntEn is 1.
- R10: The bounds in force at the capture edge decide the check, so rewriting highThr or lowThr affects every later result.
- R11: regEoc and injEoc stay set until their own clear pulse (clrRegEoc, clrInjEoc). A new result on the same edge wins over the clear.
- R12: When regTrig and injTrig are seen together while idle, the injected conversion starts first and the regular conversion follows after the injected result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regTrig | input | 1 | Regular conversion trigger pulse |
| injTrig | input | 1 | Injected conversion trigger pulse |
| contMode | input | 1 | Re-arm regular conversions continuously |
| convStart | output | 1 | One-cycle start strobe to the converter |
| convSel | output | 1 | Channel of the conversion being started: 0 regular, 1 injected |
| convAbort | output | 1 | Halts the regular conversion in flight |
| convDone | input | 1 | Converter end strobe, valid with convData |
| convData | input | DATA_W | Converted value |
| highThr | input | DATA_W | Upper window bound |
| lowThr | input | DATA_W | Lower window bound |
| wdEnReg | input | 1 | Monitor regular results |
| wdEnInj | input | 1 | Monitor injected results |
| wdIntEn | input | 1 | Route wdFlag to irq |
| clrRegEoc | input | 1 | Clear pulse for regEoc |
| clrInjEoc | input | 1 | Clear pulse for injEoc |
| clrWd | input | 1 | Clear pulse for wdFlag |
| regData | output | DATA_W | Last regular result |
| regEoc | output | 1 | Regular end-of-conversion flag |
| injData | output | DATA_W | Last injected result |
| injEoc | output | 1 | Injected end-of-conversion flag |
| wdFlag | output | 1 | Sticky window violation flag |
| irq | output | 1 | Interrupt line |

## Verification
A wrong sequencer state shows up at the converter interface within one cycle. It appears as a missing or extra convStart, a convAbort without an injected start, or a wrong convSel. The same fault then surfaces a few cycles later as results landing in the wrong register or in the wrong order. A wrong comparison or a bad flag update appears on wdFlag and irq on the first edge after the capture concerned. Because the result, flag and interrupt outputs are compared against a model on every cycle, such a fault is reported in the cycle it first becomes visible.

// File: rtl/adcSeqPkg.sv
package adcSeqPkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_REG  = 2'd1,
    SEQ_INJ  = 2'd2
  } seqState_t;

  // Capture strobes from the sequencer to the result datapath
  typedef struct packed {
    logic capInj;
    logic capReg;
  } seqStrobe_t;

endpackage

// File: rtl/adcSeqCtrl.sv
module adcSeqCtrl
  import adcSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regTrig,
  input  logic       injTrig,
  input  logic       contMode,
  input  logic       convDone,
  output logic       convStart,
  output logic       convSel,
  output logic       convAbort,
  output seqStrobe_t strb,
  output seqState_t  stateOut
);

  seqState_t state, stateNext;
  logic      regPend, regPendNext;
  logic      startNext, selNext, abortNext;

  always_comb begin
    stateNext   = state;
    regPendNext = regPend;
    startNext   = 1'b0;
    selNext     = convSel;
    abortNext   = 1'b0;
    strb        = '0;
    case (state)
      SEQ_IDLE: begin
        if (injTrig) begin
          // injected channel always wins; a coincident regular request waits
          stateNext = SEQ_INJ;
          startNext = 1'b1;
          selNext   = 1'b1;
          if (regTrig) regPendNext = 1'b1;
        end else if (regTrig || contMode || regPend) begin
          stateNext   = SEQ_REG;
          startNext   = 1'b1;
          selNext     = 1'b0;
          regPendNext = 1'b0;
        end
      end
      SEQ_REG: begin
        if (convDone) begin
          strb.capReg = 1'b1;
          if (injTrig) begin
            stateNext = SEQ_INJ;
            startNext = 1'b1;
            selNext   = 1'b1;
          end else begin
            stateNext = SEQ_IDLE;
          end
        end else if (injTrig) begin
          // preempt: halt the regular conversion and remember to redo it
          abortNext   = 1'b1;
          startNext   = 1'b1;
          selNext     = 1'b1;
          regPendNext = 1'b1;
          stateNext   = SEQ_INJ;
        end
      end
      SEQ_INJ: begin
        if (regTrig) regPendNext = 1'b1;
        if (convDone) begin
          strb.capInj = 1'b1;
          if (regPend || regTrig) begin
            stateNext   = SEQ_REG;
            startNext   = 1'b1;
            selNext     = 1'b0;
            regPendNext = 1'b0;
          end else begin
            stateNext = SEQ_IDLE;
          end
        end
      end
      default: stateNext = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= SEQ_IDLE;
      regPend   <= 1'b0;
      convStart <= 1'b0;
      convSel   <= 1'b0;
      convAbort <= 1'b0;
    end else begin
      state     <= stateNext;
      regPend   <= regPendNext;
      convStart <= startNext;
      convSel   <= selNext;
      convAbort <= abortNext;
    end
  end

  assign stateOut = state;

endmodule

// File: rtl/adcSeqData.sv
module adcSeqData
  import adcSeqPkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [DATA_W-1:0] convData,
  input  logic [DATA_W-1:0] highThr,
  input  logic [DATA_W-1:0] lowThr,
  input  logic              wdEnReg,
  input  logic              wdEnInj,
  input  logic              clrRegEoc,
  input  logic              clrInjEoc,
  input  logic              clrWd,
  output logic [DATA_W-1:0] regData,
  output logic              regEoc,
  output logic [DATA_W-1:0] injData,
  output logic              injEoc,
  output logic              wdFlag
);

  localparam int NCH = 2;  // index 0 regular, 1 injected

  logic [NCH-1:0]             capVec, clrVec, chkVec, eocVec;
  logic [NCH-1:0][DATA_W-1:0] resBus;
  logic                       outside, hit;

  assign capVec = {strb.capInj, strb.capReg};
  assign clrVec = {clrInjEoc, clrRegEoc};
  assign chkVec = {wdEnInj, wdEnReg};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [DATA_W-1:0] resR;
    logic              eocR;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        resR <= '0;
        eocR <= 1'b0;
      end else begin
        if (capVec[g]) resR <= convData;
        eocR <= capVec[g] | (eocR & ~clrVec[g]);
      end
    end
    assign resBus[g] = resR;
    assign eocVec[g] = eocR;
  end

  // window: equality with a bound counts as inside
  assign outside = (convData > highThr) || (convData < lowThr);
  assign hit     = outside && |(capVec & chkVec);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wdFlag <= 1'b0;
    else       wdFlag <= hit | (wdFlag & ~clrWd);
  end

  assign regData = resBus[0];
  assign injData = resBus[1];
  assign regEoc  = eocVec[0];
  assign injEoc  = eocVec[1];

endmodule

// File: rtl/adcSeqWatch.sv
module adcSeqWatch
  import adcSeqPkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regTrig,
  input  logic              injTrig,
  input  logic              contMode,
  output logic              convStart,
  output logic              convSel,
  output logic              convAbort,
  input  logic              convDone,
  input  logic [DATA_W-1:0] convData,
  input  logic [DATA_W-1:0] highThr,
  input  logic [DATA_W-1:0] lowThr,
  input  logic              wdEnReg,
  input  logic              wdEnInj,
  input  logic              wdIntEn,
  input  logic              clrRegEoc,
  input  logic              clrInjEoc,
  input  logic              clrWd,
  output logic [DATA_W-1:0] regData,
  output logic              regEoc,
  output logic [DATA_W-1:0] injData,
  output logic              injEoc,
  output logic              wdFlag,
  output logic              irq
);

  seqStrobe_t strb;
  seqState_t  seqState;

  adcSeqCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regTrig   (regTrig),
    .injTrig   (injTrig),
    .contMode  (contMode),
    .convDone  (convDone),
    .convStart (convStart),
    .convSel   (convSel),
    .convAbort (convAbort),
    .strb      (strb),
    .stateOut  (seqState)
  );

  adcSeqData #(.DATA_W(DATA_W)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .convData  (convData),
    .highThr   (highThr),
    .lowThr    (lowThr),
    .wdEnReg   (wdEnReg),
    .wdEnInj   (wdEnInj),
    .clrRegEoc (clrRegEoc),
    .clrInjEoc (clrInjEoc),
    .clrWd     (clrWd),
    .regData   (regData),
    .regEoc    (regEoc),
    .injData   (injData),
    .injEoc    (injEoc),
    .wdFlag    (wdFlag)
  );

  assign irq = wdFlag & wdIntEn;

endmodule

// File: rtl/adcSeqWatchChk.sv
module adcSeqWatchChk
  import adcSeqPkg::*;
#(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              convStart,
  input logic              convSel,
  input logic              convAbort,
  input logic              convDone,
  input logic              wdEnReg,
  input logic              wdEnInj,
  input logic              clrRegEoc,
  input logic              clrInjEoc,
  input logic              clrWd,
  input logic [DATA_W-1:0] regData,
  input logic              regEoc,
  input logic [DATA_W-1:0] injData,
  input logic              injEoc,
  input logic              wdFlag,
  input seqState_t         seqState
);

  a_r4_abort_starts_inj: assert property (@(posedge clk) disable iff (!rstN)
    convAbort |-> (convStart && convSel));

  a_r5_no_restart_inj: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == SEQ_INJ && !convDone) |=> !convStart);

  a_r2_results_hold: assert property (@(posedge clk) disable iff (!rstN)
    !convDone |=> ($stable(regData) && $stable(injData)));

  a_r7_disabled_no_flag: assert property (@(posedge clk) disable iff (!rstN)
    (!wdFlag && !wdEnReg && !wdEnInj) |=> !wdFlag);

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (wdFlag && !clrWd) |=> wdFlag);

  a_r11_reg_eoc_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (regEoc && !clrRegEoc) |=> regEoc);

  a_r11_inj_eoc_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (injEoc && !clrInjEoc) |=> injEoc);

endmodule

bind adcSeqWatch adcSeqWatchChk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .convStart (convStart),
  .convSel   (convSel),
  .convAbort (convAbort),
  .convDone  (convDone),
  .wdEnReg   (wdEnReg),
  .wdEnInj   (wdEnInj),
  .clrRegEoc (clrRegEoc),
  .clrInjEoc (clrInjEoc),
  .clrWd     (clrWd),
  .regData   (regData),
  .regEoc    (regEoc),
  .injData   (injData),
  .injEoc    (injEoc),
  .wdFlag    (wdFlag),
  .seqState  (seqState)
);

// File: tb/adcSeqWatch_tb.sv
`timescale 1ns/1ps
module adcSeqWatch_tb;

  localparam int DATA_W = 12;
  localparam int LAT    = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regTrig = 0, injTrig = 0, contMode = 0;
  logic convStart, convSel, convAbort;
  logic convDone = 0;
  logic [DATA_W-1:0] convData = '0;
  logic [DATA_W-1:0] highThr = '0, lowThr = '0;
  logic wdEnReg = 0, wdEnInj = 0, wdIntEn = 0;
  logic clrRegEoc = 0, clrInjEoc = 0, clrWd = 0;
  logic [DATA_W-1:0] regData, injData;
  logic regEoc, injEoc, wdFlag, irq;

  always #10 clk = ~clk;

  adcSeqWatch #(.DATA_W(DATA_W)) u_dut (.*);

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural converter
  int regVal = 0, injVal = 0;
  bit busy = 0, chan = 0, doneCh = 0;
  int cnt = 0, cyc = 0, aborts = 0;
  int startLog[$], doneLog[$], regStartCyc[$], regDoneCyc[$];

  always @(negedge clk) begin
    cyc++;
    convDone = 1'b0;
    if (!rstN) begin
      busy = 0;
    end else begin
      if (convAbort) begin busy = 0; aborts++; end
      if (convStart) begin
        busy = 1; chan = convSel; cnt = LAT;
        startLog.push_back(int'(convSel));
        if (!convSel) regStartCyc.push_back(cyc);
      end else if (busy) begin
        cnt--;
        if (cnt == 0) begin
          busy = 0; convDone = 1'b1; doneCh = chan;
          convData = DATA_W'(chan ? injVal : regVal);
          doneLog.push_back(int'(chan));
          if (!chan) regDoneCyc.push_back(cyc);
        end
      end
    end
  end

  // reference model of the visible results, updated at the capture edge
  int mReg = 0, mInj = 0;
  bit mRegEoc = 0, mInjEoc = 0, mWd = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mReg = 0; mInj = 0; mRegEoc = 0; mInjEoc = 0; mWd = 0;
    end else begin
      bit hitNow;
      hitNow = 0;
      if (clrRegEoc) mRegEoc = 0;
      if (clrInjEoc) mInjEoc = 0;
      if (clrWd) mWd = 0;
      if (convDone) begin
        if (doneCh) begin mInj = int'(convData); mInjEoc = 1; end
        else        begin mReg = int'(convData); mRegEoc = 1; end
        if ((int'(convData) > int'(highThr)) || (int'(convData) < int'(lowThr)))
          hitNow = doneCh ? wdEnInj : wdEnReg;
        if (hitNow) mWd = 1;
      end
    end
  end

  always @(negedge clk) begin
    #1;
    if (rstN && !finished) begin
      chk("R2 regData", int'(regData), mReg);
      chk("R11 regEoc", int'(regEoc), int'(mRegEoc));
      chk("R3 injData", int'(injData), mInj);
      chk("R11 injEoc", int'(injEoc), int'(mInjEoc));
      chk("R7 wdFlag", int'(wdFlag), int'(mWd));
      chk("R9 irq", int'(irq), int'(mWd && wdIntEn));
    end
  end

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clearLogs();
    startLog.delete(); doneLog.delete();
    regStartCyc.delete(); regDoneCyc.delete();
    aborts = 0;
  endtask

  initial begin
    waitN(3);
    // R1 reset state
    chk("R1 convStart", int'(convStart), 0);
    chk("R1 regEoc", int'(regEoc), 0);
    chk("R1 wdFlag", int'(wdFlag), 0);
    chk("R1 irq", int'(irq), 0);
    rstN = 1;
    highThr = 3000; lowThr = 1000;
    wdEnReg = 1; wdEnInj = 1;
    waitN(2);

    // R2 single regular conversion
    clearLogs(); regVal = 2000;
    regTrig = 1; waitN(1); regTrig = 0;
    waitN(10);
    chk("R2 starts", startLog.size(), 1);
    if (startLog.size() > 0) chk("R2 sel", startLog[0], 0);
    chk("R2 value", int'(regData), 2000);
    chk("R2 eoc", int'(regEoc), 1);

    // R11 clear of the regular flag
    clrRegEoc = 1; waitN(1); clrRegEoc = 0; waitN(1);
    chk("R11 cleared", int'(regEoc), 0);

    // R3 + R7 equality is in range
    injVal = 3000;
    injTrig = 1; waitN(1); injTrig = 0;
    waitN(10);
    chk("R3 value", int'(injData), 3000);
    chk("R3 eoc", int'(injEoc), 1);
    chk("R3 reg untouched", int'(regData), 2000);
    chk("R7 equal bound", int'(wdFlag), 0);

    // R4 preemption
    clearLogs(); regVal = 500;
    regTrig = 1; waitN(1); regTrig = 0;
    waitN(1); injTrig = 1; waitN(1); injTrig = 0;
    waitN(16);
    chk("R4 aborts", aborts, 1);
    chk("R4 starts", startLog.size(), 3);
    if (startLog.size() == 3) begin
      chk("R4 start0", startLog[0], 0);
      chk("R4 start1", startLog[1], 1);
      chk("R4 start2", startLog[2], 0);
    end
    chk("R4 dones", doneLog.size(), 2);
    if (doneLog.size() == 2) begin
      chk("R4 first inj", doneLog[0], 1);
      chk("R4 then reg", doneLog[1], 0);
    end
    chk("R7 below low", int'(wdFlag), 1);
    chk("R9 irq off", int'(irq), 0);
    wdIntEn = 1; waitN(1);
    chk("R9 irq on", int'(irq), 1);

    // R8 sticky until cleared
    waitN(3);
    chk("R8 sticky", int'(wdFlag), 1);
    clrWd = 1; waitN(1); clrWd = 0; waitN(1);
    chk("R8 cleared", int'(wdFlag), 0);

    // R5 injected trigger during injected conversion
    clearLogs(); injVal = 1500;
    injTrig = 1; waitN(1); injTrig = 0;
    waitN(1); injTrig = 1; waitN(1); injTrig = 0;
    waitN(12);
    chk("R5 starts", startLog.size(), 1);
    chk("R5 dones", doneLog.size(), 1);

    // R7 per-channel enables
    wdEnInj = 0; injVal = 4000;
    injTrig = 1; waitN(1); injTrig = 0; waitN(10);
    chk("R7 inj disabled", int'(wdFlag), 0);
    wdEnInj = 1; wdEnReg = 0; regVal = 100;
    regTrig = 1; waitN(1); regTrig = 0; waitN(10);
    chk("R7 reg disabled", int'(wdFlag), 0);
    wdEnReg = 1;

    // R10 moving the window
    regVal = 2000; highThr = 1500;
    regTrig = 1; waitN(1); regTrig = 0; waitN(10);
    chk("R10 new upper", int'(wdFlag), 1);
    clrWd = 1; waitN(1); clrWd = 0;
    highThr = 2500; lowThr = 2000;
    regTrig = 1; waitN(1); regTrig = 0; waitN(10);
    chk("R10 bound equal", int'(wdFlag), 0);
    lowThr = 2100;
    regTrig = 1; waitN(1); regTrig = 0; waitN(10);
    chk("R10 new lower", int'(wdFlag), 1);
    clrWd = 1; waitN(1); clrWd = 0;
    highThr = 3000; lowThr = 1000;

    // R6 continuous mode
    clearLogs(); contMode = 1;
    waitN(40); contMode = 0;
    waitN(15);
    chk("R6 enough", int'(regStartCyc.size() >= 4), 1);
    chk("R6 balanced", regDoneCyc.size(), regStartCyc.size());
    for (int i = 1; i < regStartCyc.size(); i++)
      if (i - 1 < regDoneCyc.size())
        chk("R6 restart gap", regStartCyc[i] - regDoneCyc[i-1], 2);

    // R12 coincident triggers
    clearLogs();
    regTrig = 1; injTrig = 1; waitN(1); regTrig = 0; injTrig = 0;
    waitN(16);
    chk("R12 starts", startLog.size(), 2);
    if (startLog.size() == 2) begin
      chk("R12 inj first", startLog[0], 1);
      chk("R12 reg second", startLog[1], 0);
    end
    chk("R12 dones", doneLog.size(), 2);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule